// File: doc/BRIEF.md
# Page-Class Bank Index Selector

This block chooses which bank of a tiled, banked last-level cache serves a request. The cache has 16 banks laid out as a 4x4 grid, with one bank next to each core tile. The rule for picking a bank depends on the class of the page being accessed:

- A page private to one core is served only by the bank of the requesting tile.
- A page of shared code is spread over the 2x2 quadrant around the requester.
- A page of shared data is interleaved by set over every bank.

The block also refuses an access whose kind does not suit the class of its page. It reports that refusal as a fault and issues no lookup.

The inputs are the physical address, the number of the requesting tile, the page class taken from the translation entry, and a bit that marks an instruction fetch. The bank number and the fault flag come out of a register stage one clock after the request. A lookup valid output goes with them.

Top module: `pagebank_sel`

## Requirements
- R1: While rst_n is low, lkup_vld and lkup_fault are 0 and lkup_bank is 0.
- R2: The result of a request with req_vld=1 appears on the outputs on the clock edge after it is presented. On a cycle with req_vld=0, lkup_vld and lkup_fault go to 0 on the next edge and lkup_bank keeps its previous value.
- R3: For class 2'b00 (private data) with req_ifetch=0, lkup_vld is 1 and lkup_bank equals req_tile, for every tile 0 to 15.
- R4: For class 2'b01 (shared instruction) with req_ifetch=1, lkup_vld is 1 and lkup_bank = {req_tile[3], req_addr[7], req_tile[1], req_addr[6]}. Tiles are numbered row*4+col, so the row is in req_tile[3:2] and the column is in req_tile[1:0]. The block offset is req_addr[5:0]. The result is a bank in the aligned 2x2 quadrant of the requesting tile.
- R5: For class 2'b10 (shared data) with req_ifetch=0, lkup_vld is 1 and lkup_bank = req_addr[9:6], whatever the tile.
- R6: An instruction fetch (req_ifetch=1) to a class 2'b00 or 2'b10 page raises a fault. So does a data access (req_ifetch=0) to a class 2'b01 page.
- R7: Class 2'b11 is reserved. It raises a fault for either kind of access.
- R8: On a fault, lkup_fault is 1, lkup_vld is 0 and lkup_bank is 0. lkup_vld and lkup_fault are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_addr | input | 40 | Physical address |
| req_tile | input | 4 | Requesting tile number (row*4+col) |
| req_cls | input | 2 | Page class: 00 private data, 01 shared instruction, 10 shared data, 11 reserved |
| req_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| lkup_vld | output | 1 | Bank lookup issued |
| lkup_bank | output | 4 | Selected bank number |
| lkup_fault | output | 1 | Access kind conflicts with the page class |

## Verification
There is only one register stage, so any fault in the selection logic shows up on lkup_bank or lkup_fault exactly one clock after the request that exposes it.

A tile field swapped or misplaced in the quadrant logic gives a bank outside the requester's quadrant only for some tiles. For that reason every tile is driven against every sub-bank address. A wrong fault decode shows either as a lookup issued with a fault, or as a bank other than zero.

A bad enable on the bank register shows as a bank that changes on an idle cycle.

// File: rtl/pagebank_pkg.sv
package pagebank_pkg;

  typedef enum logic [1:0] {
    PG_PRIV    = 2'b00,
    PG_SHINSTR = 2'b01,
    PG_SHDATA  = 2'b10,
    PG_RSVD    = 2'b11
  } pg_class_e;

endpackage

// File: rtl/pagebank_kind_chk.sv
module pagebank_kind_chk
  import pagebank_pkg::*;
(
  input  logic [1:0] cls,
  input  logic       ifetch,
  output logic       fault
);

  pg_class_e cls_e;

  always_comb begin
    cls_e = pg_class_e'(cls);
    unique case (cls_e)
      PG_PRIV:    fault = ifetch;
      PG_SHINSTR: fault = ~ifetch;
      PG_SHDATA:  fault = ifetch;
      default:    fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/pagebank_route.sv
module pagebank_route
  import pagebank_pkg::*;
#(
  parameter int GRID_DIM   = 4,
  parameter int REGION_DIM = 2,
  localparam int ROW_W  = $clog2(GRID_DIM),
  localparam int BANK_W = 2 * ROW_W,
  localparam int SUB_W  = $clog2(REGION_DIM)
) (
  input  logic [BANK_W-1:0] idx_bits,
  input  logic [BANK_W-1:0] tile,
  input  logic [1:0]        cls,
  output logic [BANK_W-1:0] bank
);

  logic [ROW_W-1:0]  tile_row, tile_col;
  logic [BANK_W-1:0] quad_bank;

  assign tile_row = tile[BANK_W-1:ROW_W];
  assign tile_col = tile[ROW_W-1:0];

  generate
    if (SUB_W == 0) begin : g_region_one
      assign quad_bank = tile;
    end else if (SUB_W >= ROW_W) begin : g_region_all
      assign quad_bank = {idx_bits[SUB_W +: ROW_W], idx_bits[0 +: ROW_W]};
    end else begin : g_region_sub
      assign quad_bank = {tile_row[ROW_W-1:SUB_W], idx_bits[SUB_W +: SUB_W],
                          tile_col[ROW_W-1:SUB_W], idx_bits[0 +: SUB_W]};
    end
  endgenerate

  always_comb begin
    unique case (pg_class_e'(cls))
      PG_PRIV:    bank = tile;
      PG_SHINSTR: bank = quad_bank;
      PG_SHDATA:  bank = idx_bits;
      default:    bank = '0;
    endcase
  end

endmodule

// File: rtl/pagebank_out_stage.sv
module pagebank_out_stage #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_fault,
  input  logic [BANK_W-1:0] in_bank,
  output logic              out_vld,
  output logic              out_fault,
  output logic [BANK_W-1:0] out_bank
);

  logic              vld_d, fault_d, bank_en;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    vld_d   = in_vld & ~in_fault;
    fault_d = in_vld & in_fault;
    bank_en = in_vld;
    bank_d  = in_fault ? '0 : in_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_fault <= 1'b0;
    end else begin
      out_vld   <= vld_d;
      out_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bank <= '0;
    end else if (bank_en) begin
      out_bank <= bank_d;
    end
  end

endmodule

// File: rtl/pagebank_sel.sv
module pagebank_sel #(
  parameter int ADDR_W     = 40,
  parameter int BLK_OFF_W  = 6,
  parameter int GRID_DIM   = 4,
  parameter int REGION_DIM = 2,
  localparam int BANK_W = 2 * $clog2(GRID_DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_tile,
  input  logic [1:0]        req_cls,
  input  logic              req_ifetch,
  output logic              lkup_vld,
  output logic [BANK_W-1:0] lkup_bank,
  output logic              lkup_fault
);

  logic              kind_fault;
  logic [BANK_W-1:0] sel_bank;

  pagebank_kind_chk kind_i (
    .cls    (req_cls),
    .ifetch (req_ifetch),
    .fault  (kind_fault)
  );

  pagebank_route #(
    .GRID_DIM   (GRID_DIM),
    .REGION_DIM (REGION_DIM)
  ) route_i (
    .idx_bits (req_addr[BLK_OFF_W +: BANK_W]),
    .tile     (req_tile),
    .cls      (req_cls),
    .bank     (sel_bank)
  );

  pagebank_out_stage #(
    .BANK_W (BANK_W)
  ) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (req_vld),
    .in_fault  (kind_fault),
    .in_bank   (sel_bank),
    .out_vld   (lkup_vld),
    .out_fault (lkup_fault),
    .out_bank  (lkup_bank)
  );

endmodule

// File: rtl/pagebank_sel_chk.sv
module pagebank_sel_chk #(
  parameter int ADDR_W    = 40,
  parameter int BLK_OFF_W = 6,
  parameter int BANK_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANK_W-1:0] req_tile,
  input logic [1:0]        req_cls,
  input logic              req_ifetch,
  input logic              lkup_vld,
  input logic [BANK_W-1:0] lkup_bank,
  input logic              lkup_fault
);

  localparam int HALF = BANK_W / 2;

  // R8
  excl_vld_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lkup_vld && lkup_fault));

  // R8
  fault_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkup_fault |-> (lkup_bank == '0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!lkup_vld && !lkup_fault && $stable(lkup_bank)));

  // R3
  private_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cls == 2'b00 && !req_ifetch) |=>
      (lkup_vld && lkup_bank == $past(req_tile)));

  // R4
  shinstr_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cls == 2'b01 && req_ifetch) |=>
      (lkup_vld && lkup_bank[BANK_W-1] == $past(req_tile[BANK_W-1])
               && lkup_bank[HALF-1] == $past(req_tile[HALF-1])));

  // R5
  shdata_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cls == 2'b10 && !req_ifetch) |=>
      (lkup_vld && lkup_bank == $past(req_addr[BLK_OFF_W +: BANK_W])));

  // R7
  reserved_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cls == 2'b11) |=> lkup_fault);

  // R6
  kind_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_ifetch != (req_cls == 2'b01))) |=> lkup_fault);

endmodule

bind pagebank_sel pagebank_sel_chk #(
  .ADDR_W    (ADDR_W),
  .BLK_OFF_W (BLK_OFF_W),
  .BANK_W    (BANK_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_vld    (req_vld),
  .req_addr   (req_addr),
  .req_tile   (req_tile),
  .req_cls    (req_cls),
  .req_ifetch (req_ifetch),
  .lkup_vld   (lkup_vld),
  .lkup_bank  (lkup_bank),
  .lkup_fault (lkup_fault)
);

// File: tb/pagebank_sel_tb_top.sv
`timescale 1ns/1ps
module pagebank_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [39:0] req_addr;
  logic [3:0]  req_tile;
  logic [1:0]  req_cls;
  logic        req_ifetch;
  logic        lkup_vld;
  logic [3:0]  lkup_bank;
  logic        lkup_fault;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pagebank_sel dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_addr   (req_addr),
    .req_tile   (req_tile),
    .req_cls    (req_cls),
    .req_ifetch (req_ifetch),
    .lkup_vld   (lkup_vld),
    .lkup_bank  (lkup_bank),
    .lkup_fault (lkup_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input logic ev, input logic ef, input logic [3:0] eb);
    n_chk = n_chk + 1;
    if (lkup_vld !== ev || lkup_fault !== ef || lkup_bank !== eb) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual vld=%b fault=%b bank=%0d expected vld=%b fault=%b bank=%0d",
               req, lkup_vld, lkup_fault, lkup_bank, ev, ef, eb);
    end
  endtask

  // present one request at a negedge, sample one edge later at the next negedge
  task automatic issue(input logic [39:0] a, input logic [3:0] t, input logic [1:0] c,
                       input logic f);
    req_vld = 1'b1; req_addr = a; req_tile = t; req_cls = c; req_ifetch = f;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_vld = 1'b1; req_addr = 40'h3C0; req_tile = 4'd9;
    req_cls = 2'b10; req_ifetch = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0, 4'd0);
    req_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_private();
    for (int t = 0; t < 16; t++) begin
      issue({24'hABCD00, 6'(t * 5), 10'h3FF}, 4'(t), 2'b00, 1'b0);
      check("R3 private local bank", 1'b1, 1'b0, 4'(t));
    end
  endtask

  task automatic t_shinstr();
    for (int t = 0; t < 16; t++) begin
      for (int s = 0; s < 4; s++) begin
        logic [39:0] a;
        logic [3:0]  eb;
        a  = {30'h155, 2'(s), 2'(3 - s), 6'h2A};
        eb = {t[3], a[7], t[1], a[6]};
        issue(a, 4'(t), 2'b01, 1'b1);
        check("R4 shared-instruction quadrant", 1'b1, 1'b0, eb);
      end
    end
  endtask

  task automatic t_shdata();
    for (int b = 0; b < 16; b++) begin
      logic [39:0] a;
      a = {30'h2AA55, 4'(b), 6'(b * 3)};
      issue(a, 4'(15 - b), 2'b10, 1'b0);
      check("R5 shared-data interleave", 1'b1, 1'b0, 4'(b));
    end
  endtask

  task automatic t_fault();
    issue(40'h3C0, 4'd5, 2'b00, 1'b1);
    check("R6 fetch to private page", 1'b0, 1'b1, 4'd0);
    issue(40'h3C0, 4'd5, 2'b10, 1'b1);
    check("R6 fetch to shared-data page", 1'b0, 1'b1, 4'd0);
    issue(40'h3C0, 4'd10, 2'b01, 1'b0);
    check("R6 data access to shared-instruction page", 1'b0, 1'b1, 4'd0);
    issue(40'h3C0, 4'd12, 2'b11, 1'b0);
    check("R7 reserved class data", 1'b0, 1'b1, 4'd0);
    issue(40'h3C0, 4'd12, 2'b11, 1'b1);
    check("R7 reserved class fetch", 1'b0, 1'b1, 4'd0);
    issue(40'h240, 4'd7, 2'b10, 1'b0);
    check("R8 fault clears to valid lookup", 1'b1, 1'b0, 4'd9);
    issue(40'h240, 4'd7, 2'b10, 1'b1);
    check("R8 fault forces bank zero", 1'b0, 1'b1, 4'd0);
  endtask

  task automatic t_idle();
    issue(40'h2C0, 4'd1, 2'b10, 1'b0);
    check("R2 one-cycle latency", 1'b1, 1'b0, 4'd11);
    req_addr = 40'h000; req_tile = 4'd0; req_cls = 2'b00; req_ifetch = 1'b0;
    @(negedge clk);
    check("R2 idle holds bank, drops valid", 1'b0, 1'b0, 4'd11);
    req_cls = 2'b11; req_ifetch = 1'b1;
    @(negedge clk);
    check("R2 idle ignores reserved class", 1'b0, 1'b0, 4'd11);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_private();
    t_shinstr();
    t_shdata();
    t_fault();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule